// File: doc/BRIEF.md
# Bus clock-enable strobe tree

This block sits in the system clock domain of a small microcontroller and produces one-cycle clock-enable strobes for every derived domain. The derived domains are the main AHB bus, a fast and a slow peripheral bus, one timer enable per peripheral bus, a system tick reference, an SD-card interface and an ADC. Logic in each domain runs from the system clock and advances only in cycles where its strobe is high. No real clocks are divided or switched.

Software supplies a divider code for the AHB, for each peripheral bus and for the ADC, plus a bit that picks the ADC's count base. It also supplies a code naming the system clock source. The source choice goes through a two-stage registered handshake. The status output shows the active source once the handshake completes. While a switch is in progress, every derived strobe is held low and every divider counter is frozen. A combinational flag reports divider settings that would push a peripheral bus past its rated fraction of the AHB rate.

Divider changes never cut a period short. A new code is taken only at the strobe that closes the running period.

Top module: `clk_strobe_tree`

## Requirements
- R1: `src_sel` codes are 0 = internal RC oscillator, 1 = external crystal oscillator, 2 = PLL. Code 3 is ignored and leaves the pending source unchanged. `src_stat` never shows 3.
- R2: The AHB divider D comes from `ahb_code` as 0→1, 1→2, 2→4, 3→8, 4→16, 5→64, 6→128, 7→256, and 8 or above→512. Outside reset and switchover, `ahb_en` is high for one cycle in every D cycles.
- R3: Each peripheral divider comes from its code as 0→1, 1→2, 2→4, 3→8, and 4 to 7→16. `fast_en` and `slow_en` pulse once per D pulses of `ahb_en`, always in a cycle where `ahb_en` is high.
- R4: When a peripheral divider is 1, that bus's timer enable equals its bus enable.
- R5: When a peripheral divider D is above 1, the timer enable pulses on AHB pulse D/2 and on AHB pulse D of each bus period. This is twice the bus rate.
- R6: `tick_en` pulses on every 8th `ahb_en` pulse.
- R7: `sd_en` pulses on every 2nd `ahb_en` pulse, with no setting that changes this.
- R8: The ADC divider is 2×(`adc_code`+1). With `adc_from_pll` = 0 it counts `ahb_en` pulses. With `adc_from_pll` = 1 it counts every running system-clock cycle.
- R9: Take a change of `src_sel` to a new valid code. `switching` rises in the same cycle. `src_stat` takes the new code on the second clock edge after the change. `switching` stays high until `src_stat` matches, and `src_stat` changes only after a cycle with `switching` high.
- R10: `ratio_err` is high exactly when (AHB divider × fast divider) < 2 or (AHB divider × slow divider) < 4, evaluated on the present codes.
- R11: A code change to any divider takes effect only after the strobe that ends the current period. No strobe period is shorter than either the old or the new setting.
- R12: The reset is synchronous and active low. During reset all strobes are low and `src_stat` is 0. After release, a divider of D gives its first strobe on its D-th counted event.
- R13: While `switching` is high, every strobe output is low and no divider counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Requested system clock source |
| ahb_code | input | AHB_CW | AHB divider code |
| fast_code | input | PB_CW | Fast peripheral bus divider code |
| slow_code | input | PB_CW | Slow peripheral bus divider code |
| adc_code | input | ADC_CW | ADC divider code |
| adc_from_pll | input | 1 | ADC count base: 0 AHB pulses, 1 every system cycle |
| ahb_en | output | 1 | AHB domain strobe |
| fast_en | output | 1 | Fast peripheral bus strobe |
| slow_en | output | 1 | Slow peripheral bus strobe |
| fast_tmr_en | output | 1 | Timer strobe for the fast bus |
| slow_tmr_en | output | 1 | Timer strobe for the slow bus |
| tick_en | output | 1 | System tick reference strobe |
| sd_en | output | 1 | SD-card interface strobe |
| adc_en | output | 1 | ADC strobe |
| src_stat | output | 2 | Active source after synchronisation |
| switching | output | 1 | Source switchover in progress |
| ratio_err | output | 1 | Peripheral divider ratio out of range |

## Verification
The bench builds the block with its default code widths (4-bit AHB, 3-bit peripheral, 2-bit ADC). These widths make every listed divider reachable, up to the 512 AHB setting and the 16 peripheral setting. A reference model advances per cycle from the codes and forecasts every strobe, which exercises both timer regimes and both ADC count bases. The stimulus changes codes in the middle of a period, switches source to each code including the ignored one, and redirects a switch before it has settled. A second reset with an AHB divider of 4 confirms the timing of the first strobe after release.

// File: rtl/clk_tree_pkg.sv
// Package: shared widths, source codes and divider decoders for the strobe tree.
// Assumes the decoders are used with codes no wider than 32 bits.
package clk_tree_pkg;

    localparam int AHB_DW = 10;   // holds the largest AHB divider (512)
    localparam int PB_DW  = 5;    // holds the largest peripheral divider (16)
    localparam int ADC_DW = 4;    // holds the largest ADC divider (8)

    typedef enum logic [1:0] {
        SRC_INT_RC  = 2'd0,
        SRC_EXT_OSC = 2'd1,
        SRC_PLL     = 2'd2,
        SRC_RSVD    = 2'd3
    } src_t;

    // AHB code to divide ratio
    function automatic int unsigned ahb_div_of(input int unsigned c);
        case (c)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 8;
            4:       return 16;
            5:       return 64;
            6:       return 128;
            7:       return 256;
            default: return 512;
        endcase
    endfunction

    // Peripheral bus code to divide ratio
    function automatic int unsigned pb_div_of(input int unsigned c);
        case (c)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 8;
            default: return 16;
        endcase
    endfunction

    // ADC code to divide ratio (even ratios only)
    function automatic int unsigned adc_div_of(input int unsigned c);
        return (c + 1) * 2;
    endfunction

endpackage

// File: rtl/strobe_div.sv
// Module: strobe_div
// Counts qualifying events and emits a one-cycle strobe on the last event
// of each period, plus a half-period strobe for double-rate consumers.
// Assumes div_req of 0 means 1; the requested ratio is latched in reset and
// again only at the end of each period, so periods are never cut short.
module strobe_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev,
    input  logic [W-1:0] div_req,
    output logic         strobe,
    output logic         mid,
    output logic [W-1:0] div_now
);

    logic [W-1:0] cnt;
    logic [W-1:0] dact;
    logic [W-1:0] req_safe;
    logic         last;

    // Guard against a zero ratio request
    assign req_safe = (div_req == '0) ? W'(1) : div_req;

    // Last event of the running period
    assign last = (cnt == dact - W'(1));

    // Output strobes: end of period and half-period point
    assign strobe  = ev & last;
    assign mid     = ev & (dact > W'(1)) & (cnt == (dact >> 1) - W'(1));
    assign div_now = dact;

    // Event counter with ratio reload only at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dact <= req_safe;
        end else if (ev) begin
            if (last) begin
                cnt  <= '0;
                dact <= req_safe;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < dact);

    // R11
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(strobe)) |-> $stable(dact));

endmodule

// File: rtl/src_track.sv
// Module: src_track
// Registers the requested clock source through two stages and flags the
// switchover window; code 3 is ignored and keeps the pending request.
// Assumes the request is already in the system clock domain.
module src_track
    import clk_tree_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_in,
    output logic [1:0] stat,
    output logic       busy
);

    src_t stage_q;
    src_t stat_q;
    src_t eff;

    // Filter out the reserved code
    assign eff = (sel_in == 2'(SRC_RSVD)) ? stage_q : src_t'(sel_in);

    // Switch window: request differs from either stage
    assign busy = (eff != stage_q) || (stage_q != stat_q);
    assign stat = stat_q;

    // Two-stage handshake register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= SRC_INT_RC;
            stat_q  <= SRC_INT_RC;
        end else begin
            stage_q <= eff;
            stat_q  <= stage_q;
        end
    end

    // R1
    stat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat != 2'(SRC_RSVD));

    // R9
    stat_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(stat)) |-> $past(busy));

endmodule

// File: rtl/clk_strobe_tree.sv
// Module: clk_strobe_tree (top)
// Builds the strobe tree: AHB strobe from the system clock, peripheral,
// tick and SD strobes from AHB pulses, ADC strobe from AHB pulses or raw
// cycles, and double-rate timer strobes per peripheral bus.
// Assumes all inputs are synchronous to clk; codes may change at any time.
module clk_strobe_tree
    import clk_tree_pkg::*;
#(
    parameter int AHB_CW = 4,
    parameter int PB_CW  = 3,
    parameter int ADC_CW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic [AHB_CW-1:0] ahb_code,
    input  logic [PB_CW-1:0]  fast_code,
    input  logic [PB_CW-1:0]  slow_code,
    input  logic [ADC_CW-1:0] adc_code,
    input  logic              adc_from_pll,
    output logic              ahb_en,
    output logic              fast_en,
    output logic              slow_en,
    output logic              fast_tmr_en,
    output logic              slow_tmr_en,
    output logic              tick_en,
    output logic              sd_en,
    output logic              adc_en,
    output logic [1:0]        src_stat,
    output logic              switching,
    output logic              ratio_err
);

    localparam int N_PB       = 2;
    localparam int TICK_RATIO = 8;
    localparam int SD_RATIO   = 2;
    localparam int TK_W       = $clog2(TICK_RATIO) + 1;
    localparam int SD_W       = $clog2(SD_RATIO) + 1;

    logic             run;
    logic             adc_ev;
    logic [PB_CW-1:0] pb_code [N_PB];
    logic [N_PB-1:0]  pb_bus;
    logic [N_PB-1:0]  pb_tmr;

    logic              unused_ahb_mid;
    logic [AHB_DW-1:0] unused_ahb_div;
    logic              unused_tick_mid;
    logic [TK_W-1:0]   unused_tick_div;
    logic              unused_sd_mid;
    logic [SD_W-1:0]   unused_sd_div;
    logic              unused_adc_mid;
    logic [ADC_DW-1:0] unused_adc_div;

    // Source handshake and switchover window
    src_track u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_in (src_sel),
        .stat   (src_stat),
        .busy   (switching)
    );

    // Root event: every cycle outside reset and switchover
    assign run = rst_n & ~switching;

    // AHB divider on raw cycles
    strobe_div #(.W(AHB_DW)) u_ahb (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (run),
        .div_req (AHB_DW'(ahb_div_of(32'(ahb_code)))),
        .strobe  (ahb_en),
        .mid     (unused_ahb_mid),
        .div_now (unused_ahb_div)
    );

    // Peripheral code fan-in for the generate loop
    assign pb_code[0] = fast_code;
    assign pb_code[1] = slow_code;

    // One divider per peripheral bus; timer doubles the rate if ratio > 1
    for (genvar g = 0; g < N_PB; g++) begin : g_pbus
        logic             s_end;
        logic             s_mid;
        logic [PB_DW-1:0] d_now;

        strobe_div #(.W(PB_DW)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ahb_en),
            .div_req (PB_DW'(pb_div_of(32'(pb_code[g])))),
            .strobe  (s_end),
            .mid     (s_mid),
            .div_now (d_now)
        );

        assign pb_bus[g] = s_end;
        assign pb_tmr[g] = (d_now == PB_DW'(1)) ? s_end : (s_end | s_mid);
    end

    assign fast_en     = pb_bus[0];
    assign slow_en     = pb_bus[1];
    assign fast_tmr_en = pb_tmr[0];
    assign slow_tmr_en = pb_tmr[1];

    // Fixed tick reference from AHB pulses
    strobe_div #(.W(TK_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ahb_en),
        .div_req (TK_W'(TICK_RATIO)),
        .strobe  (tick_en),
        .mid     (unused_tick_mid),
        .div_now (unused_tick_div)
    );

    // Fixed SD-card strobe from AHB pulses
    strobe_div #(.W(SD_W)) u_sd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ahb_en),
        .div_req (SD_W'(SD_RATIO)),
        .strobe  (sd_en),
        .mid     (unused_sd_mid),
        .div_now (unused_sd_div)
    );

    // ADC count base select
    assign adc_ev = adc_from_pll ? run : ahb_en;

    // ADC divider
    strobe_div #(.W(ADC_DW)) u_adc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (adc_ev),
        .div_req (ADC_DW'(adc_div_of(32'(adc_code)))),
        .strobe  (adc_en),
        .mid     (unused_adc_mid),
        .div_now (unused_adc_div)
    );

    // Ratio check on the programmed codes
    always_comb begin
        ratio_err = ((ahb_div_of(32'(ahb_code)) * pb_div_of(32'(fast_code))) < 32'd2) ||
                    ((ahb_div_of(32'(ahb_code)) * pb_div_of(32'(slow_code))) < 32'd4);
    end

    // R6
    tick_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |-> ahb_en);

    // R7
    sd_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_en |-> ahb_en);

    // R3
    bus_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_en | slow_en) |-> ahb_en);

    // R13
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switching |-> !(ahb_en | fast_en | slow_en | fast_tmr_en | slow_tmr_en |
                        tick_en | sd_en | adc_en));

endmodule

// File: tb/clk_strobe_tree_tb.sv
// Scoreboard bench: a per-cycle reference model pushes expected outputs
// into a queue; a monitor pops them and compares against the design.
module clk_strobe_tree_tb;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] ahb_code = 4'd0;
    logic [2:0] fast_code = 3'd1;
    logic [2:0] slow_code = 3'd2;
    logic [1:0] adc_code = 2'd0;
    logic       adc_from_pll = 1'b0;

    logic ahb_en, fast_en, slow_en, fast_tmr_en, slow_tmr_en;
    logic tick_en, sd_en, adc_en, switching, ratio_err;
    logic [1:0] src_stat;

    clk_strobe_tree u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ahb_code(ahb_code),
        .fast_code(fast_code), .slow_code(slow_code), .adc_code(adc_code),
        .adc_from_pll(adc_from_pll), .ahb_en(ahb_en), .fast_en(fast_en),
        .slow_en(slow_en), .fast_tmr_en(fast_tmr_en), .slow_tmr_en(slow_tmr_en),
        .tick_en(tick_en), .sd_en(sd_en), .adc_en(adc_en), .src_stat(src_stat),
        .switching(switching), .ratio_err(ratio_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       ahb, fast, slow, ftmr, stmr, tick, sd, adc;
        logic [1:0] stat;
        logic       busy, ratio;
    } exp_t;

    exp_t sb_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic check1(input string tag, input string what,
                          input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Requirement-level decoders
    function automatic int m_ahb(input int c);
        if (c <= 4) return 1 << c;
        if (c <= 8) return 1 << (c + 1);
        return 512;
    endfunction
    function automatic int m_pb(input int c);
        return (c >= 4) ? 16 : (1 << c);
    endfunction
    function automatic int m_adc(input int c);
        return 2 * c + 2;
    endfunction

    // Model state: events seen since last pulse, and latched ratio
    int m_ae = 0, m_ad = 1, m_te = 0, m_se = 0, m_ce = 0, m_cd = 2;
    int m_pe [2] = '{0, 0};
    int m_pd [2] = '{1, 1};
    int m_stage = 0, m_stat = 0;

    // Reference model: forecast this cycle, then advance to the next edge
    always @(negedge clk) begin : model
        exp_t e;
        int   eff, pc[2];
        bit   busy, run, a_hit, c_base;
        bit   p_hit[2], p_tmr[2];
        pc[0] = int'(fast_code);
        pc[1] = int'(slow_code);
        eff   = (src_sel == 2'd3) ? m_stage : int'(src_sel);
        busy  = (eff != m_stage) || (m_stage != m_stat);
        run   = rst_n && !busy;
        a_hit = run && (m_ae + 1 == m_ad);
        for (int i = 0; i < 2; i++) begin
            p_hit[i] = a_hit && (m_pe[i] + 1 == m_pd[i]);
            if (m_pd[i] == 1) p_tmr[i] = p_hit[i];
            else p_tmr[i] = a_hit && (((m_pe[i] + 1) % (m_pd[i] / 2)) == 0);
        end
        c_base = adc_from_pll ? run : a_hit;
        e.ahb  = a_hit;
        e.fast = p_hit[0];
        e.slow = p_hit[1];
        e.ftmr = p_tmr[0];
        e.stmr = p_tmr[1];
        e.tick = a_hit && (m_te + 1 == 8);
        e.sd   = a_hit && (m_se + 1 == 2);
        e.adc  = c_base && (m_ce + 1 == m_cd);
        e.stat = 2'(m_stat);
        e.busy = busy;
        e.ratio = (m_ahb(int'(ahb_code)) * m_pb(pc[0]) < 2) ||
                  (m_ahb(int'(ahb_code)) * m_pb(pc[1]) < 4);
        sb_q.push_back(e);
        if (!rst_n) begin
            m_ae = 0; m_ad = m_ahb(int'(ahb_code));
            for (int i = 0; i < 2; i++) begin m_pe[i] = 0; m_pd[i] = m_pb(pc[i]); end
            m_te = 0; m_se = 0; m_ce = 0; m_cd = m_adc(int'(adc_code));
            m_stage = 0; m_stat = 0;
        end else begin
            m_stat  = m_stage;
            m_stage = eff;
            if (run) begin
                if (a_hit) begin m_ae = 0; m_ad = m_ahb(int'(ahb_code)); end
                else m_ae++;
            end
            if (a_hit) begin
                for (int i = 0; i < 2; i++) begin
                    if (p_hit[i]) begin m_pe[i] = 0; m_pd[i] = m_pb(pc[i]); end
                    else m_pe[i]++;
                end
                m_te = (m_te + 1) % 8;
                m_se = (m_se + 1) % 2;
            end
            if (c_base) begin
                if (m_ce + 1 == m_cd) begin m_ce = 0; m_cd = m_adc(int'(adc_code)); end
                else m_ce++;
            end
        end
    end

    // Monitor: pop the forecast and compare each output
    always @(negedge clk) begin : monitor
        exp_t e;
        #2;
        if (!done && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check1("R2", "ahb_en", 2'(ahb_en), 2'(e.ahb));
            check1("R3", "fast_en", 2'(fast_en), 2'(e.fast));
            check1("R3", "slow_en", 2'(slow_en), 2'(e.slow));
            check1("R4 R5", "fast_tmr_en", 2'(fast_tmr_en), 2'(e.ftmr));
            check1("R4 R5", "slow_tmr_en", 2'(slow_tmr_en), 2'(e.stmr));
            check1("R6", "tick_en", 2'(tick_en), 2'(e.tick));
            check1("R7", "sd_en", 2'(sd_en), 2'(e.sd));
            check1("R8", "adc_en", 2'(adc_en), 2'(e.adc));
            check1("R1 R9", "src_stat", src_stat, e.stat);
            check1("R9 R13", "switching", 2'(switching), 2'(e.busy));
            check1("R10", "ratio_err", 2'(ratio_err), 2'(e.ratio));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: stimulus sequence
    initial begin : driver
        int k;
        cyc(4);
        @(negedge clk); #3;
        // R12: reset state
        check1("R12", "reset strobes", 2'(ahb_en | fast_en | slow_en | tick_en | sd_en | adc_en), 2'd0);
        check1("R12", "reset src_stat", src_stat, 2'd0);
        cyc(1);
        rst_n = 1'b1;
        cyc(200);
        ahb_code = 4'd2;             // R11: change mid-period
        cyc(37);
        fast_code = 3'd0;            // R4: timer equals bus
        cyc(150);
        slow_code = 3'd4;            // R5: divider 16
        cyc(300);
        adc_from_pll = 1'b1;         // R8: raw-cycle base
        adc_code = 2'd3;
        cyc(100);
        adc_code = 2'd1;
        cyc(50);
        src_sel = 2'd2;              // R9: switch to PLL
        cyc(20);
        src_sel = 2'd3;              // R1: reserved code ignored
        cyc(20);
        src_sel = 2'd1;              // R9: redirected before settling
        cyc(1);
        src_sel = 2'd0;
        cyc(30);
        ahb_code = 4'd0;             // R10: ratio violations
        fast_code = 3'd0;
        cyc(10);
        slow_code = 3'd1;
        cyc(10);
        fast_code = 3'd3;
        slow_code = 3'd2;
        adc_from_pll = 1'b0;
        ahb_code = 4'd8;             // R2: largest divider
        cyc(9000);
        ahb_code = 4'd5;
        cyc(600);
        ahb_code = 4'd2;
        rst_n = 1'b0;                // R12: second reset, first strobe timing
        cyc(3);
        rst_n = 1'b1;
        k = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk); #3;
            if (ahb_en) begin k = i; break; end
        end
        check1("R12", "first ahb_en cycle after release", 2'(k), 2'd0 + 2'(4 % 4));
        check1("R12", "first ahb_en index", 2'(k >> 2), 2'd1);
        cyc(50);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin : watchdog
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion earlier", WATCHDOG_CYC);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule